// File: doc/BRIEF.md
# Multiplexer-Tree Programmable Logic Module

This block is one programmable logic module for a logic fabric. Its function comes from a small tree of multiplexers, not from a look-up table. A four-way multiplexer and a final two-way multiplexer together have eight legs: five data legs and three select legs. Each leg is set by its own configuration field. The field ties the leg to one of the eight module inputs, to the complement of that input, or to constant 0 or constant 1.

With four data legs and two select legs, the four-way stage alone can realise any function of three variables. The final two-way stage lets the module gate or extend that result, for example into a four-input AND. Wider functions are built by chaining modules. A cascade output always carries the unregistered tree result, so it can feed an input of the next module.

The configuration is loaded serially through a shift chain while a configuration-enable pin is high. A parameter picks one of two variants. The combinational variant has no storage. The sequential variant adds an output flip-flop with a synchronous reset and a clock enable, and a configuration bit chooses whether the output is taken from that flip-flop or straight from the tree.

Top module: `mux_logic_module`

## Requirements
- R1: Each leg field is 5 bits: bits [2:0] hold an input index 0..7 and bits [4:3] hold the kind, where 0 = true input, 1 = complemented input, 2 = constant 0 and 3 = constant 1.
- R2: The tree result is D4 when S2 is 0. When S2 is 1 it is the data leg D0..D3 chosen by the index {S1,S0}. Leg k occupies configuration bits [5k+4:5k], in the leg order D0, D1, D2, D3, D4, S0, S1, S2.
- R3: While `cfg_en` is high, each clock moves the 41-bit configuration word one place toward bit 0, and `cfg_in` enters bit 40. Shifting a word in over 41 clocks, bit 0 first, loads that word. Bit 40 is the output-select bit.
- R4: While `cfg_en` is high, both `y` and `casc_y` are 0.
- R5: While `cfg_en` is low, the configuration word does not change.
- R6: A clock with `rst` high sets every leg to constant 0, clears the output-select bit and clears the output flip-flop, so both outputs are 0.
- R7: In the sequential variant, the flip-flop loads the tree result on a clock where `rst` is low, `cfg_en` is low and `ce` is high, and it holds its value on every other clock.
- R8: In the sequential variant, output-select bit 1 drives `y` from the flip-flop and bit 0 drives `y` from the tree. In the combinational variant the bit has no effect and `y` follows the tree.
- R9: `casc_y` always carries the unregistered tree result, whatever the output-select bit is, so it can feed an input of another module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Serial configuration data |
| ce | input | 1 | Clock enable of the output flip-flop |
| din | input | 8 | Logic inputs |
| y | output | 1 | Module output, registered or combinational |
| casc_y | output | 1 | Unregistered tree result for chaining |

## Verification
Three mappings are each run exhaustively over all 256 input patterns: a three-input XOR, a three-input majority and a four-input AND. Each mapping uses scattered input indices, so a wrong index decode or a swapped pair of select legs gives a wrong result on some pattern. The XOR needs complemented data legs, the majority needs constant legs mixed with true legs, and the AND needs the final two-way stage with an input on its select leg.

A mapping built only from constant-1 legs separates the constant-1 and constant-0 encodings. A chained pair of modules is run with registered output selected on the first module, which shows that the cascade path skips the flip-flop.

// File: rtl/mlm_pkg.sv
package mlm_pkg;
    localparam int MLM_NUM_IN   = 8;
    localparam int MLM_IDX_W    = $clog2(MLM_NUM_IN);
    localparam int MLM_NUM_DATA = 5;
    localparam int MLM_NUM_SEL  = 3;
    localparam int MLM_NUM_LEG  = MLM_NUM_DATA + MLM_NUM_SEL;
    localparam int MLM_KIND_W   = 2;
    localparam int MLM_LEG_W    = MLM_KIND_W + MLM_IDX_W;
    localparam int MLM_CFG_W    = MLM_NUM_LEG * MLM_LEG_W + 1;

    // leg positions in the configuration word
    localparam int LEG_D4 = 4;
    localparam int LEG_S0 = 5;

    typedef enum logic [MLM_KIND_W-1:0] {
        KIND_TRUE = 2'd0,
        KIND_INV  = 2'd1,
        KIND_ZERO = 2'd2,
        KIND_ONE  = 2'd3
    } leg_kind_e;

    typedef struct packed {
        leg_kind_e              kind;
        logic [MLM_IDX_W-1:0]   idx;
    } leg_cfg_t;

    typedef struct packed {
        logic                           use_reg;
        leg_cfg_t [MLM_NUM_LEG-1:0]     legs;
    } mod_cfg_t;

    function automatic mod_cfg_t cfg_reset_value();
        mod_cfg_t c;
        c.use_reg = 1'b0;
        for (int k = 0; k < MLM_NUM_LEG; k++) begin
            c.legs[k].kind = KIND_ZERO;
            c.legs[k].idx  = '0;
        end
        return c;
    endfunction
endpackage

// File: rtl/mlm_cfg_chain.sv
module mlm_cfg_chain
    import mlm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_en,
    input  logic     cfg_in,
    output mod_cfg_t cfg
);
    localparam int W = MLM_CFG_W;

    typedef struct packed {
        logic [W-1:0] word;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_en) begin
            st_d.word = {cfg_in, st_q.word[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.word <= cfg_reset_value();
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = mod_cfg_t'(st_q.word);

    assert_shift_top_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (st_q.word[W-1] == $past(cfg_in)));

    assert_shift_move_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (st_q.word[W-2:0] == $past(st_q.word[W-1:1])));

    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(st_q.word));
endmodule

// File: rtl/mlm_leg_sel.sv
module mlm_leg_sel
    import mlm_pkg::*;
(
    input  leg_cfg_t              leg,
    input  logic [MLM_NUM_IN-1:0] din,
    output logic                  val
);
    logic picked;

    always_comb begin
        picked = din[leg.idx];
        unique case (leg.kind)
            KIND_TRUE: val = picked;
            KIND_INV:  val = ~picked;
            KIND_ZERO: val = 1'b0;
            KIND_ONE:  val = 1'b1;
            default:   val = 1'b0;
        endcase
    end
endmodule

// File: rtl/mlm_mux_tree.sv
module mlm_mux_tree
    import mlm_pkg::*;
(
    input  logic [MLM_NUM_DATA-1:0] data,
    input  logic [MLM_NUM_SEL-1:0]  sel,
    output logic                    y
);
    localparam int FIRST_W = MLM_NUM_SEL - 1;
    localparam int FIRST_N = 1 << FIRST_W;

    logic [FIRST_N-1:0] first_in;
    logic               first_y;

    assign first_in = data[FIRST_N-1:0];

    always_comb begin
        first_y = first_in[sel[FIRST_W-1:0]];
        y = sel[MLM_NUM_SEL-1] ? first_y : data[MLM_NUM_DATA-1];
    end
endmodule

// File: rtl/mlm_out_stage.sv
module mlm_out_stage #(
    parameter bit SEQUENTIAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic cfg_en,
    input  logic use_reg,
    input  logic tree_y,
    output logic y
);
    generate
        if (SEQUENTIAL) begin : g_seq
            typedef struct packed {
                logic bit_v;
            } ff_t;

            ff_t ff_d, ff_q;

            always_comb begin
                ff_d = ff_q;
                if (ce && !cfg_en) begin
                    ff_d.bit_v = tree_y;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    ff_q.bit_v <= 1'b0;
                end else begin
                    ff_q <= ff_d;
                end
            end

            always_comb begin
                if (cfg_en) y = 1'b0;
                else if (use_reg) y = ff_q.bit_v;
                else y = tree_y;
            end

            assert_ff_reset_R6: assert property (@(posedge clk)
                rst |=> (ff_q.bit_v == 1'b0));

            assert_ff_load_R7: assert property (@(posedge clk) disable iff (rst)
                (ce && !cfg_en) |=> (ff_q.bit_v == $past(tree_y)));

            assert_ff_hold_R7: assert property (@(posedge clk) disable iff (rst)
                (!ce || cfg_en) |=> $stable(ff_q.bit_v));
        end else begin : g_comb
            logic unused_ok;
            assign unused_ok = &{1'b0, clk, rst, ce, use_reg};
            assign y = cfg_en ? 1'b0 : tree_y;
        end
    endgenerate
endmodule

// File: rtl/mux_logic_module.sv
module mux_logic_module
    import mlm_pkg::*;
#(
    parameter bit SEQUENTIAL = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_en,
    input  logic                  cfg_in,
    input  logic                  ce,
    input  logic [MLM_NUM_IN-1:0] din,
    output logic                  y,
    output logic                  casc_y
);
    mod_cfg_t               cfg;
    logic [MLM_NUM_LEG-1:0] leg_val;
    logic                   tree_y;

    mlm_cfg_chain u_chain (
        .clk    (clk),
        .rst    (rst),
        .cfg_en (cfg_en),
        .cfg_in (cfg_in),
        .cfg    (cfg)
    );

    generate
        for (genvar k = 0; k < MLM_NUM_LEG; k++) begin : g_leg
            mlm_leg_sel u_leg (
                .leg (cfg.legs[k]),
                .din (din),
                .val (leg_val[k])
            );
        end
    endgenerate

    mlm_mux_tree u_tree (
        .data (leg_val[MLM_NUM_DATA-1:0]),
        .sel  (leg_val[MLM_NUM_LEG-1:MLM_NUM_DATA]),
        .y    (tree_y)
    );

    mlm_out_stage #(.SEQUENTIAL(SEQUENTIAL)) u_out (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .cfg_en  (cfg_en),
        .use_reg (cfg.use_reg),
        .tree_y  (tree_y),
        .y       (y)
    );

    assign casc_y = cfg_en ? 1'b0 : tree_y;

    assert_quiet_cfg_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> (!y && !casc_y));

    assert_bypass_leg_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !leg_val[MLM_NUM_LEG-1]) |-> (casc_y == leg_val[LEG_D4]));

    assert_comb_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && (!SEQUENTIAL || !cfg.use_reg)) |-> (y == casc_y));
endmodule

// File: tb/mux_logic_module_tb_top.sv
`timescale 1ns/1ps
module mux_logic_module_tb_top;
    import mlm_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce = 1'b0;
    logic       cfg_en_a = 1'b0, cfg_in_a = 1'b0;
    logic       cfg_en_b = 1'b0, cfg_in_b = 1'b0;
    logic [7:0] din = '0;
    logic       y_a, casc_a, y_b, casc_b;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    mux_logic_module #(.SEQUENTIAL(1'b1)) dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en_a), .cfg_in(cfg_in_a),
        .ce(ce), .din(din), .y(y_a), .casc_y(casc_a)
    );

    mux_logic_module #(.SEQUENTIAL(1'b0)) dut_c (
        .clk(clk), .rst(rst), .cfg_en(cfg_en_b), .cfg_in(cfg_in_b),
        .ce(ce), .din({din[7:1], casc_a}), .y(y_b), .casc_y(casc_b)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    function automatic leg_cfg_t mk(input leg_kind_e k, input int idx);
        leg_cfg_t l;
        l.kind = k;
        l.idx  = idx[2:0];
        return l;
    endfunction

    function automatic mod_cfg_t all_zero();
        mod_cfg_t c;
        c.use_reg = 1'b0;
        for (int k = 0; k < 8; k++) c.legs[k] = mk(KIND_ZERO, 0);
        return c;
    endfunction

    // legs: 0..4 = D0..D4, 5..7 = S0..S2
    task automatic load(input logic which_b, input mod_cfg_t w);
        logic [40:0] bits;
        bits = w;
        @(negedge clk);
        for (int i = 0; i < 41; i++) begin
            if (which_b) begin cfg_en_b = 1'b1; cfg_in_b = bits[i]; end
            else begin cfg_en_a = 1'b1; cfg_in_a = bits[i]; end
            if (i == 20) begin
                #1;
                if (which_b) begin
                    chk(y_b, 1'b0, "R4", "y during cfg");
                    chk(casc_b, 1'b0, "R4", "casc during cfg");
                end else begin
                    chk(y_a, 1'b0, "R4", "y during cfg");
                    chk(casc_a, 1'b0, "R4", "casc during cfg");
                end
            end
            @(negedge clk);
        end
        cfg_en_a = 1'b0;
        cfg_en_b = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        din = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(y_a, 1'b0, "R6", "reset y");
        chk(casc_a, 1'b0, "R6", "reset casc");
        chk(y_b, 1'b0, "R6", "reset y comb");
    endtask

    task automatic test_xor3();
        mod_cfg_t c = all_zero();
        c.legs[5] = mk(KIND_TRUE, 5);
        c.legs[6] = mk(KIND_TRUE, 2);
        c.legs[7] = mk(KIND_ONE, 0);
        c.legs[0] = mk(KIND_TRUE, 7);
        c.legs[1] = mk(KIND_INV, 7);
        c.legs[2] = mk(KIND_INV, 7);
        c.legs[3] = mk(KIND_TRUE, 7);
        load(1'b0, c);
        for (int v = 0; v < 256; v++) begin
            din = v[7:0];
            #1;
            chk(y_a, din[5] ^ din[2] ^ din[7], "R1", "xor3");
            @(negedge clk);
        end
    endtask

    task automatic test_maj3();
        mod_cfg_t c = all_zero();
        c.legs[5] = mk(KIND_TRUE, 1);
        c.legs[6] = mk(KIND_TRUE, 6);
        c.legs[7] = mk(KIND_ONE, 0);
        c.legs[0] = mk(KIND_ZERO, 0);
        c.legs[1] = mk(KIND_TRUE, 3);
        c.legs[2] = mk(KIND_TRUE, 3);
        c.legs[3] = mk(KIND_ONE, 0);
        load(1'b0, c);
        for (int v = 0; v < 256; v++) begin
            din = v[7:0];
            #1;
            chk(y_a, (din[1] & din[6]) | (din[1] & din[3]) | (din[6] & din[3]), "R2", "maj3");
            @(negedge clk);
        end
    endtask

    task automatic test_and4();
        mod_cfg_t c = all_zero();
        c.legs[7] = mk(KIND_TRUE, 0);
        c.legs[4] = mk(KIND_ZERO, 0);
        c.legs[5] = mk(KIND_TRUE, 3);
        c.legs[6] = mk(KIND_TRUE, 4);
        c.legs[3] = mk(KIND_TRUE, 7);
        load(1'b0, c);
        for (int v = 0; v < 256; v++) begin
            din = v[7:0];
            #1;
            chk(y_a, din[0] & din[3] & din[4] & din[7], "R2", "and4");
            @(negedge clk);
        end
    endtask

    task automatic test_consts();
        mod_cfg_t c = all_zero();
        c.legs[5] = mk(KIND_ONE, 0);
        c.legs[6] = mk(KIND_ONE, 0);
        c.legs[7] = mk(KIND_ONE, 0);
        c.legs[3] = mk(KIND_ONE, 0);
        load(1'b0, c);
        din = 8'h00;
        #1;
        chk(y_a, 1'b1, "R1", "const one");
        // D4 path with S2 const 0 and complemented input
        c = all_zero();
        c.legs[4] = mk(KIND_INV, 6);
        load(1'b0, c);
        din = 8'h40;
        #1;
        chk(y_a, 1'b0, "R2", "d4 inv hi");
        din = 8'h00;
        #1;
        chk(y_a, 1'b1, "R2", "d4 inv lo");
        // cfg_en low: config must not change while cfg_in toggles
        for (int i = 0; i < 8; i++) begin
            cfg_in_a = i[0];
            @(negedge clk);
        end
        #1;
        chk(y_a, 1'b1, "R5", "cfg held");
    endtask

    task automatic test_seq();
        mod_cfg_t c = all_zero();
        c.use_reg = 1'b1;
        c.legs[4] = mk(KIND_TRUE, 2);
        load(1'b0, c);
        ce = 1'b1;
        din = 8'h04;
        @(negedge clk);
        #1;
        chk(y_a, 1'b1, "R7", "reg load 1");
        chk(casc_a, 1'b1, "R9", "casc comb");
        ce = 1'b0;
        din = 8'h00;
        #1;
        chk(y_a, 1'b1, "R8", "reg selected, not comb");
        chk(casc_a, 1'b0, "R9", "casc bypass reg");
        @(negedge clk);
        #1;
        chk(y_a, 1'b1, "R7", "hold ce low");
        ce = 1'b1;
        @(negedge clk);
        #1;
        chk(y_a, 1'b0, "R7", "reg load 0");
        din = 8'h04;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(y_a, 1'b0, "R6", "sync reset clears");
        ce = 1'b0;
    endtask

    task automatic test_cascade();
        mod_cfg_t c = all_zero();
        c.use_reg = 1'b1;
        c.legs[7] = mk(KIND_TRUE, 0);
        c.legs[5] = mk(KIND_TRUE, 3);
        c.legs[6] = mk(KIND_TRUE, 4);
        c.legs[3] = mk(KIND_TRUE, 7);
        load(1'b0, c);
        c.legs[7] = mk(KIND_TRUE, 0);
        c.legs[5] = mk(KIND_TRUE, 1);
        c.legs[6] = mk(KIND_TRUE, 2);
        c.legs[3] = mk(KIND_TRUE, 5);
        load(1'b1, c);
        ce = 1'b0;
        for (int v = 0; v < 256; v++) begin
            din = v[7:0];
            #1;
            chk(y_b, &{din[0], din[1], din[2], din[3], din[4], din[5], din[7]},
                "R9", "chained and7");
            @(negedge clk);
        end
        din = 8'hFF;
        #1;
        chk(y_b, 1'b1, "R8", "comb variant ignores select bit");
        chk(y_a, 1'b0, "R8", "seq variant stays registered");
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_xor3();
        test_maj3();
        test_and4();
        test_consts();
        test_seq();
        test_cascade();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule